// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write-Permission Arbiter

This block holds the status and control byte of a serial EEPROM and decides, for every decoded write command, whether that write may proceed. It receives single-cycle strobes from an upstream command decoder (set write latch, clear write latch, status write with a data byte, array write with an address, and a completion pulse from the internal engine). It also receives the level of the active-low write-protect pin and a busy flag from the write engine. It returns the readable status byte, a one-cycle grant or deny for each array write and each status write, and a select that steers accesses to the identification page instead of the main array.

A small state machine tracks the internal write cycle. In `ST_IDLE` the block accepts commands. A granted status write takes the transition IDLE→SR_BUSY. A granted array write takes IDLE→ARR_BUSY. In either busy state a completion pulse takes the transition back to IDLE (SR_BUSY→IDLE, ARR_BUSY→IDLE) and clears the write latch. The nonvolatile fields (hardware-protect enable, block-protect pair and page lock) come from a parameter at reset. The volatile fields start at zero.

Top module: `eesr_status_ctrl`

## Requirements
- R1: After reset the status byte shows the parameter `RESET_NV` (bits {3:hw-protect enable, 2:page lock, 1:0 block-protect pair}). With the default of 0 the byte reads 0x00. `id_page_sel` and all grant and deny outputs read 0.
- R2: Status byte layout: bit7 hw-protect enable, bit6 page select, bit5 constant 0, bit4 page lock, bits3:2 block-protect pair, bit1 write latch, bit0 busy. A status write loads bits 7, 6, 4, 3 and 2 only.
- R3: Busy (bit0) is 1 while the machine is in SR_BUSY or ARR_BUSY, or while `engine_busy` is high. While busy, every command is ignored: no grant, no deny and no latch change.
- R4: `cmd_wren` sets the write latch and `cmd_wrdi` clears it. If both arrive in the same cycle, clearing wins.
- R5: For array writes with the page select at 0, the block-protect pair decodes as follows over the top two address bits. 00 protects nothing. 01 protects addresses with top bits 11 (0x3000–0x3FFF). 10 protects addresses with top bit 1 (0x2000–0x3FFF). 11 protects every address. A write to a protected address is denied.
- R6: With the write latch at 0, every array write and every status write is denied.
- R7: Hardware protection is active when bit7 is 1 and `wp_n` is 0. While it is active, status writes are denied and unprotected array writes are still granted.
- R8: A granted write raises busy on the next cycle. The completion pulse then clears the write latch and busy.
- R9: A status write whose data has bits 6 and 4 both set leaves the page select and the page lock unchanged.
- R10: A status write can set the page select, which drives `id_page_sel`. The select survives the completion of that status write. It clears on a completion pulse in IDLE (a finished read) or on completion of an array write. Array writes to the page ignore block protection.
- R11: Once the page lock is 1, it stays 1 until reset. While it is set, every array write with the page select at 1 is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Set-write-latch strobe |
| cmd_wrdi | input | 1 | Clear-write-latch strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_write | input | 1 | Array-write strobe |
| write_addr | input | ADDR_W | Array-write address |
| op_done | input | 1 | Read or write completion pulse |
| wp_n | input | 1 | Write-protect pin level (low = protect) |
| engine_busy | input | 1 | Write engine busy |
| status_byte | output | 8 | Readable status byte |
| write_grant | output | 1 | Array write allowed (one-cycle pulse) |
| write_deny | output | 1 | Array write refused (one-cycle pulse) |
| sr_grant | output | 1 | Status write allowed (one-cycle pulse) |
| sr_deny | output | 1 | Status write refused (one-cycle pulse) |
| id_page_sel | output | 1 | Accesses go to the identification page |

## Verification
The bench builds the block with `ADDR_W` = 14 and `RESET_NV` = 0. The 14-bit address space brings the exact protection edges within reach: 0x2FFF/0x3000, 0x1FFF/0x2000, 0x0000 and 0x3FFF. The all-zero preset starts the run unprotected and unlocked. Every protection mode is then reached through status writes, including the page lock, which is tested last because it cannot be undone.

// File: rtl/eesr_pkg.sv
package eesr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SR_BUSY  = 2'd1,
        ST_ARR_BUSY = 2'd2
    } eesr_state_e;

    // bit positions inside the status byte
    localparam int unsigned SB_RDY  = 0;
    localparam int unsigned SB_WEL  = 1;
    localparam int unsigned SB_BP0  = 2;
    localparam int unsigned SB_BP1  = 3;
    localparam int unsigned SB_LOCK = 4;
    localparam int unsigned SB_PSEL = 6;
    localparam int unsigned SB_HWEN = 7;

    // nonvolatile image, same order as the RESET_NV parameter
    typedef struct packed {
        logic       hw_en;
        logic       lock;
        logic [1:0] bp;
    } eesr_nv_t;

endpackage

// File: rtl/eesr_block_decode.sv
module eesr_block_decode (
    input  logic [1:0] bp,
    input  logic [1:0] addr_top,
    output logic       in_protected
);
    always_comb begin
        unique case (bp)
            2'b00:   in_protected = 1'b0;
            2'b01:   in_protected = (addr_top == 2'b11);
            2'b10:   in_protected = addr_top[1];
            default: in_protected = 1'b1;
        endcase
    end
endmodule

// File: rtl/eesr_write_arbiter.sv
module eesr_write_arbiter (
    input  logic wel,
    input  logic hw_en,
    input  logic wp_n,
    input  logic lock,
    input  logic psel,
    input  logic in_protected,
    output logic arr_ok,
    output logic sr_ok
);
    logic hw_lock;

    always_comb begin
        hw_lock = hw_en & ~wp_n;
        arr_ok  = wel & (psel ? ~lock : ~in_protected);
        sr_ok   = wel & ~hw_lock;
    end
endmodule

// File: rtl/eesr_status_ctrl.sv
module eesr_status_ctrl #(
    parameter int unsigned ADDR_W   = 14,
    parameter logic [3:0]  RESET_NV = 4'b0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] write_addr,
    input  logic              op_done,
    input  logic              wp_n,
    input  logic              engine_busy,
    output logic [7:0]        status_byte,
    output logic              write_grant,
    output logic              write_deny,
    output logic              sr_grant,
    output logic              sr_deny,
    output logic              id_page_sel
);
    import eesr_pkg::*;

    localparam eesr_nv_t NV_INIT = eesr_nv_t'(RESET_NV);
    localparam int unsigned TOP_LSB = ADDR_W - 2;

    eesr_state_e state, state_nx;
    eesr_nv_t    nv;
    logic        wel, psel;
    logic        rdy, accept;
    logic        in_protected, arr_ok, sr_ok;
    logic        take_sr, take_arr, both_page_bits;

    eesr_block_decode u_decode (
        .bp           (nv.bp),
        .addr_top     (write_addr[TOP_LSB +: 2]),
        .in_protected (in_protected)
    );

    eesr_write_arbiter u_arb (
        .wel          (wel),
        .hw_en        (nv.hw_en),
        .wp_n         (wp_n),
        .lock         (nv.lock),
        .psel         (psel),
        .in_protected (in_protected),
        .arr_ok       (arr_ok),
        .sr_ok        (sr_ok)
    );

    always_comb begin
        rdy            = (state != ST_IDLE) | engine_busy;
        accept         = ~rdy;
        take_sr        = accept & cmd_wrsr & sr_ok;
        take_arr       = accept & ~cmd_wrsr & cmd_write & arr_ok;
        both_page_bits = wrsr_data[SB_PSEL] & wrsr_data[SB_LOCK];
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_sr)       state_nx = ST_SR_BUSY;
                else if (take_arr) state_nx = ST_ARR_BUSY;
            end
            ST_SR_BUSY:  if (op_done) state_nx = ST_IDLE;
            ST_ARR_BUSY: if (op_done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // register contents and response pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv          <= NV_INIT;
            wel         <= 1'b0;
            psel        <= 1'b0;
            write_grant <= 1'b0;
            write_deny  <= 1'b0;
            sr_grant    <= 1'b0;
            sr_deny     <= 1'b0;
        end else begin
            write_grant <= 1'b0;
            write_deny  <= 1'b0;
            sr_grant    <= 1'b0;
            sr_deny     <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (op_done) psel <= 1'b0;
                    if (accept) begin
                        if (cmd_wrdi)      wel <= 1'b0;
                        else if (cmd_wren) wel <= 1'b1;
                        if (cmd_wrsr) begin
                            sr_grant <= sr_ok;
                            sr_deny  <= ~sr_ok;
                        end else if (cmd_write) begin
                            write_grant <= arr_ok;
                            write_deny  <= ~arr_ok;
                        end
                    end
                    if (take_sr) begin
                        nv.hw_en <= wrsr_data[SB_HWEN];
                        nv.bp    <= {wrsr_data[SB_BP1], wrsr_data[SB_BP0]};
                        if (!both_page_bits) begin
                            psel    <= wrsr_data[SB_PSEL];
                            nv.lock <= nv.lock | wrsr_data[SB_LOCK];
                        end
                    end
                end
                ST_SR_BUSY: begin
                    if (op_done) wel <= 1'b0;
                end
                ST_ARR_BUSY: begin
                    if (op_done) begin
                        wel  <= 1'b0;
                        psel <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign status_byte = {nv.hw_en, psel, 1'b0, nv.lock, nv.bp, wel, rdy};
    assign id_page_sel = psel;

endmodule

// File: rtl/eesr_status_chk.sv
module eesr_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       both_bits,
    input logic [1:0] addr_top,
    input logic       wp_n,
    input logic       rdy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       lock,
    input logic       psel,
    input logic       hw_en,
    input logic       write_grant,
    input logic       write_deny,
    input logic       sr_grant,
    input logic       sr_deny
);
    assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rdy) |-> !(write_grant || write_deny || sr_grant || sr_deny));

    assert_wren_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi && !rdy) |=> wel);

    assert_full_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        write_grant |-> ($past(psel) || $past(bp) != 2'b11));

    assert_quarter_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (write_grant && !$past(psel) && $past(bp) == 2'b01) |-> $past(addr_top) != 2'b11);

    assert_need_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (write_grant || sr_grant) |-> $past(wel));

    assert_hw_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant |-> !($past(hw_en) && !$past(wp_n)));

    assert_grant_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (write_grant || sr_grant) |-> rdy);

    assert_page_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_grant && $past(both_bits)) |-> (psel == $past(psel) && lock == $past(lock)));

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock) |-> lock);

    assert_lock_page_R11: assert property (@(posedge clk) disable iff (!rst_n)
        write_grant |-> !($past(psel) && $past(lock)));

    assert_one_answer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(write_grant && write_deny) && !(sr_grant && sr_deny));
endmodule

bind eesr_status_ctrl eesr_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wren    (cmd_wren),
    .cmd_wrdi    (cmd_wrdi),
    .both_bits   (wrsr_data[6] & wrsr_data[4]),
    .addr_top    (write_addr[ADDR_W-1 -: 2]),
    .wp_n        (wp_n),
    .rdy         (status_byte[0]),
    .wel         (status_byte[1]),
    .bp          (status_byte[3:2]),
    .lock        (status_byte[4]),
    .psel        (status_byte[6]),
    .hw_en       (status_byte[7]),
    .write_grant (write_grant),
    .write_deny  (write_deny),
    .sr_grant    (sr_grant),
    .sr_deny     (sr_deny)
);

// File: tb/eesr_status_ctrl_test.sv
module eesr_status_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0;
    logic [7:0] wrsr_data = '0;
    logic [AW-1:0] write_addr = '0;
    logic op_done = 0, wp_n = 1, engine_busy = 0;
    logic [7:0] status_byte;
    logic write_grant, write_deny, sr_grant, sr_deny, id_page_sel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eesr_status_ctrl #(.ADDR_W(AW), .RESET_NV(4'b0000)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_write(cmd_write),
        .write_addr(write_addr), .op_done(op_done), .wp_n(wp_n),
        .engine_busy(engine_busy), .status_byte(status_byte),
        .write_grant(write_grant), .write_deny(write_deny),
        .sr_grant(sr_grant), .sr_deny(sr_deny), .id_page_sel(id_page_sel)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_wren();
        cmd_wren = 1; @(negedge clk); cmd_wren = 0;
    endtask

    task automatic pulse_wrdi();
        cmd_wrdi = 1; @(negedge clk); cmd_wrdi = 0;
    endtask

    task automatic pulse_done();
        op_done = 1; @(negedge clk); op_done = 0;
    endtask

    task automatic try_write(logic [AW-1:0] a, logic exp, string tag);
        cmd_write = 1; write_addr = a;
        @(negedge clk);
        check(tag, {write_grant, write_deny}, {exp, ~exp});
        cmd_write = 0;
        if (exp) pulse_done();
    endtask

    task automatic try_wrsr(logic [7:0] d, logic exp, string tag);
        cmd_wrsr = 1; wrsr_data = d;
        @(negedge clk);
        check(tag, {sr_grant, sr_deny}, {exp, ~exp});
        cmd_wrsr = 0;
        if (exp) pulse_done();
    endtask

    task automatic t_reset();
        check("R1 status after reset", status_byte, 8'h00);
        check("R1 page select after reset", id_page_sel, 0);
        check("R1 pulses after reset", {write_grant, write_deny, sr_grant, sr_deny}, 0);
    endtask

    task automatic t_latch();
        pulse_wren();
        check("R4 wren sets latch", status_byte[1], 1);
        pulse_wrdi();
        check("R4 wrdi clears latch", status_byte[1], 0);
        pulse_wren();
        cmd_wren = 1; cmd_wrdi = 1; @(negedge clk); cmd_wren = 0; cmd_wrdi = 0;
        check("R4 wrdi wins over wren", status_byte[1], 0);
    endtask

    task automatic t_no_latch();
        try_write(14'h0000, 0, "R6 array write without latch");
        try_wrsr(8'h00, 0, "R6 status write without latch");
    endtask

    task automatic t_layout();
        pulse_wren();
        try_wrsr(8'hAC, 1, "R2 status write 0xAC granted");
        check("R2 layout, bit5 and low bits not loaded", status_byte, 8'h8C);
        pulse_wren();
        try_wrsr(8'h00, 1, "R2 restore");
        check("R2 restored", status_byte, 8'h00);
    endtask

    task automatic set_bp(logic [1:0] bp);
        pulse_wren();
        try_wrsr({4'b0, bp, 2'b0}, 1, "R5 set block protect");
        check("R5 bp field", status_byte[3:2], bp);
    endtask

    task automatic t_blocks();
        pulse_wren(); try_write(14'h3FFF, 1, "R5 bp00 top address");
        set_bp(2'b01);
        pulse_wren(); try_write(14'h2FFF, 1, "R5 bp01 0x2FFF open");
        pulse_wren(); try_write(14'h3000, 0, "R5 bp01 0x3000 locked");
        set_bp(2'b10);
        pulse_wren(); try_write(14'h1FFF, 1, "R5 bp10 0x1FFF open");
        pulse_wren(); try_write(14'h2000, 0, "R5 bp10 0x2000 locked");
        set_bp(2'b11);
        pulse_wren(); try_write(14'h0000, 0, "R5 bp11 0x0000 locked");
        set_bp(2'b00);
    endtask

    task automatic t_autoclear();
        pulse_wren();
        cmd_write = 1; write_addr = 14'h0010;
        @(negedge clk);
        cmd_write = 0;
        check("R8 latch and busy during cycle", status_byte, 8'h03);
        pulse_done();
        check("R8 latch and busy after completion", status_byte, 8'h00);
    endtask

    task automatic t_busy();
        pulse_wren();
        cmd_write = 1; write_addr = 14'h0010;
        @(negedge clk);
        check("R3 first write granted", write_grant, 1);
        cmd_wrdi = 1;
        @(negedge clk);
        check("R3 write during cycle ignored", {write_grant, write_deny}, 0);
        check("R3 wrdi during cycle ignored", status_byte[1], 1);
        cmd_write = 0; cmd_wrdi = 0;
        pulse_done();
        engine_busy = 1;
        @(negedge clk);
        check("R3 busy bit follows engine", status_byte[0], 1);
        pulse_wren();
        engine_busy = 0;
        @(negedge clk);
        check("R3 wren while busy ignored", status_byte, 8'h00);
    endtask

    task automatic t_hw();
        pulse_wren();
        try_wrsr(8'h80, 1, "R7 enable hw protect");
        check("R7 enable bit", status_byte, 8'h80);
        wp_n = 0;
        pulse_wren();
        try_wrsr(8'h00, 0, "R7 status write refused under pin");
        try_write(14'h0100, 1, "R7 unprotected array write allowed");
        pulse_wren();
        try_write(14'h3FFF, 1, "R7 top array write allowed");
        wp_n = 1;
        pulse_wren();
        try_wrsr(8'h00, 1, "R7 pin high releases");
        check("R7 cleared", status_byte, 8'h00);
    endtask

    task automatic t_page();
        pulse_wren();
        try_wrsr(8'h50, 1, "R9 dual page bits write");
        check("R9 page bits unchanged", status_byte, 8'h00);
        pulse_wren();
        try_wrsr(8'h40, 1, "R10 set page select");
        check("R10 select kept after status write", id_page_sel, 1);
        pulse_done();
        check("R10 read completion clears select", id_page_sel, 0);
        pulse_wren();
        try_wrsr(8'h4C, 1, "R10 select with full protect");
        check("R10 status", status_byte, 8'h4C);
        pulse_wren();
        try_write(14'h0000, 1, "R10 page write ignores block protect");
        check("R10 select cleared by write completion", status_byte, 8'h0C);
        pulse_wren();
        try_wrsr(8'h00, 1, "R10 restore");
    endtask

    task automatic t_lock();
        pulse_wren();
        try_wrsr(8'h10, 1, "R11 set lock");
        check("R11 lock bit", status_byte, 8'h10);
        pulse_wren();
        try_wrsr(8'h40, 1, "R11 select page");
        check("R11 lock kept with select", status_byte, 8'h50);
        pulse_wren();
        try_write(14'h0000, 0, "R11 locked page write refused");
        pulse_done();
        check("R11 select cleared, latch kept", status_byte, 8'h12);
        try_write(14'h0000, 1, "R11 main array still writable");
        pulse_wren();
        try_wrsr(8'h00, 1, "R11 attempt to clear lock");
        check("R11 lock sticky", status_byte, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_no_latch();
        t_layout();
        t_blocks();
        t_autoclear();
        t_busy();
        t_hw();
        t_page();
        t_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule